// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Controller (Master or Slave)

This block is a full-duplex serial peripheral controller that a processor drives through four small registers. As a master it generates the serial clock itself and shifts a word of 1 to 8 bits out on its data output while it takes in the same number of bits from its data input. As a slave it follows an external master that frames each word with an active-low select and supplies the clock. The external clock, data and select are passed through two-stage synchronizers, so the external clock must run at no more than a quarter of the system clock.

Software reads received words from a receive buffer, not from the shift register. Only reads are double buffered. Three sticky flags are kept: transfer complete, write collision and receive overrun. An interrupt request follows the complete flag when interrupts are enabled. Data is sent most significant bit first. The serial clock idles low, the output data changes on its falling edge, and the input data is sampled on its rising edge.

Register map (2-bit address). Address 0 is data: a write loads the transmit word and a read returns the receive buffer. Address 1 is control/status: bit0 enable, bit1 master select, bit2 interrupt enable, bit4 complete flag, bit5 collision flag, bit6 overrun flag, bit7 busy (read only); bit3 reads 0. Address 2 is word length: bits[2:0] hold the bit count minus one. Address 3 is the clock divider N.

Top module: `spi_port`

## Requirements
- R1: After reset every register reads 0 and sckOut, mosiOut, misoOut and irq are low.
- R2: With enable=1 and master=1, a data write starts a transfer at once. sckOut idles low and has a period of 2*(N+1) system clocks, where N is the value at address 3. The busy bit reads 1 until the transfer ends.
- R3: In master mode the low L bits of the written word go out on mosiOut, most significant first, where L = length field + 1 (1 to 8). mosiOut changes only while sckOut is low and holds steady across each rising edge.
- R4: Each transfer is full duplex. At its end the received L bits can be read at address 0, right-aligned, with the upper bits 0, and the complete flag (bit4) sets.
- R5: irq is high exactly while the interrupt enable and the complete flag are both 1.
- R6: A data write made while busy sets the collision flag (bit5) and is dropped: the current transfer still sends its original word and is not disturbed.
- R7: If the receive buffer has not been read when a transfer ends, the overrun flag (bit6) sets, the buffer keeps the older word and the new word is lost.
- R8: A read of address 0 marks the buffer read. Each flag stays set until software writes 0 to its bit at address 1; writing 1 there leaves it set.
- R9: With enable=1 and master=0, the block is a slave. A falling nssIn starts a transfer: the loaded word goes out on misoOut, MSB first, changing after falling sckIn edges, and mosiIn is sampled on rising sckIn edges. The complete flag sets when nssIn returns high.
- R10: In slave mode, if no data write falls between two transfers, the second transfer sends the current shift register contents. After an 8-bit transfer these are the word just received.
- R11: With enable=0 a data write starts nothing: sckOut stays low, busy stays 0 and no flag sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 2 | Register select |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (marks data read) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request |
| sckOut | output | 1 | Serial clock in master mode |
| mosiOut | output | 1 | Serial data out in master mode |
| misoIn | input | 1 | Serial data in in master mode |
| sckIn | input | 1 | Serial clock from an external master |
| mosiIn | input | 1 | Serial data from an external master |
| nssIn | input | 1 | Active-low frame select from an external master |
| misoOut | output | 1 | Serial data to an external master |

## Verification
A shift register that has lost its place shows up right away on the serial output pins: the bit order seen at the pins no longer matches the written word, and the received word read back at address 0 is wrong when the frame ends. A bit or divider counter that is off by one changes the measured clock period or the number of rising edges within the first few edges of the clock. A broken buffer-full or collision path only shows on the next status read or the next data read. For that reason the bench reads those back straight after each frame.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_LEN  = 2'd2;
  localparam logic [1:0] ADDR_DIV  = 2'd3;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_MST  = 1;
  localparam int CTRL_IE   = 2;
  localparam int CTRL_RSVD = 3;
  localparam int CTRL_DONE = 4;
  localparam int CTRL_COLL = 5;
  localparam int CTRL_OVR  = 6;
  localparam int CTRL_BUSY = 7;

  typedef struct packed {
    logic load;    // take a new transmit word
    logic sample;  // capture the input bit
    logic shift;   // advance the shift register
    logic finish;  // move the word to the receive buffer
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_MSHIFT = 2'd1,
    ST_MDONE  = 2'd2,
    ST_SLAVE  = 2'd3
  } ctlState_t;
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RESET_VAL;
    end else begin
      stage[0] <= din;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/spi_port_dp.sv
module spi_port_dp import spi_port_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LEN_W-1:0]  lenSel,
  input  logic              serIn,
  input  logic              rdClear,
  output logic              shiftMsb,
  output logic [DATA_W-1:0] rxBuf,
  output logic              rxFull
);
  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] lenMask;
  logic [DATA_W-1:0] alignedWord;
  logic [LEN_W-1:0]  padAmt;
  logic              sampled;

  // words shorter than DATA_W are left-aligned so the MSB pin always sees bit DATA_W-1
  always_comb begin
    padAmt      = LEN_W'(DATA_W - 1) - lenSel;
    lenMask     = {DATA_W{1'b1}} >> padAmt;
    alignedWord = wrData << padAmt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sampled  <= 1'b0;
    end else begin
      if (strobe.sample) sampled <= serIn;
      if (strobe.load) shiftReg <= alignedWord;
      else if (strobe.shift) shiftReg <= {shiftReg[DATA_W-2:0], sampled};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf  <= '0;
      rxFull <= 1'b0;
    end else if (strobe.finish && !rxFull) begin
      rxBuf  <= shiftReg & lenMask;
      rxFull <= 1'b1;
    end else if (rdClear) begin
      rxFull <= 1'b0;
    end
  end

  assign shiftMsb = shiftReg[DATA_W-1];
endmodule

// File: rtl/spi_port_ctl.sv
module spi_port_ctl import spi_port_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DIV_W = 8,
  parameter int LEN_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              sckSync,
  input  logic              nssSync,
  input  logic              rxFull,
  output dpStrobe_t         strobe,
  output logic [LEN_W-1:0]  lenSel,
  output logic [DIV_W-1:0]  divider,
  output logic              enable,
  output logic              isMaster,
  output logic              irqEn,
  output logic              sckOut,
  output logic              xferBusy,
  output logic              doneFlag,
  output logic              collFlag,
  output logic              ovrFlag,
  output logic              rdClear,
  output logic              irq
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  ctlState_t        state;
  logic [DIV_W-1:0] halfCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             sckPrev, nssPrev;
  logic             wrDataReg, wrCtrl, wrLen, wrDiv;
  logic             idle, halfTick, lastBit;
  logic             sckRise, sckFall, nssFall, nssRise;
  logic             unusedWr;

  assign unusedWr  = ^{regWrData[CTRL_RSVD], regWrData[CTRL_BUSY]};

  assign wrDataReg = regWr && (regAddr == ADDR_DATA);
  assign wrCtrl    = regWr && (regAddr == ADDR_CTRL);
  assign wrLen     = regWr && (regAddr == ADDR_LEN);
  assign wrDiv     = regWr && (regAddr == ADDR_DIV);
  assign rdClear   = regRd && (regAddr == ADDR_DATA);

  assign idle      = (state == ST_IDLE);
  assign sckRise   = sckSync && !sckPrev;
  assign sckFall   = !sckSync && sckPrev;
  assign nssFall   = !nssSync && nssPrev;
  assign nssRise   = nssSync && !nssPrev;
  assign halfTick  = (state == ST_MSHIFT) && (halfCnt == divider);
  assign lastBit   = (bitCnt == (CNT_W'(lenSel) + CNT_W'(1)));

  always_comb begin
    strobe.load   = wrDataReg && enable && idle;
    strobe.sample = (halfTick && !sckOut) || ((state == ST_SLAVE) && sckRise);
    strobe.shift  = (halfTick && sckOut) || ((state == ST_SLAVE) && sckFall);
    strobe.finish = (state == ST_MDONE) || ((state == ST_SLAVE) && nssRise);
  end

  // transfer sequencing: master clock generation and slave edge tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      bitCnt  <= '0;
      sckOut  <= 1'b0;
      sckPrev <= 1'b0;
      nssPrev <= 1'b1;
    end else begin
      sckPrev <= sckSync;
      nssPrev <= nssSync;
      case (state)
        ST_IDLE: begin
          halfCnt <= '0;
          bitCnt  <= '0;
          if (wrDataReg && enable && isMaster) state <= ST_MSHIFT;
          else if (enable && !isMaster && nssFall) state <= ST_SLAVE;
        end
        ST_MSHIFT: begin
          if (halfTick) begin
            halfCnt <= '0;
            sckOut  <= !sckOut;
            if (!sckOut) bitCnt <= bitCnt + CNT_W'(1);
            else if (lastBit) state <= ST_MDONE;
          end else begin
            halfCnt <= halfCnt + DIV_W'(1);
          end
        end
        ST_MDONE: state <= ST_IDLE;
        ST_SLAVE: if (nssRise) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // software-visible configuration and sticky flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      isMaster <= 1'b0;
      irqEn    <= 1'b0;
      lenSel   <= '0;
      divider  <= '0;
      doneFlag <= 1'b0;
      collFlag <= 1'b0;
      ovrFlag  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        enable   <= regWrData[CTRL_EN];
        isMaster <= regWrData[CTRL_MST];
        irqEn    <= regWrData[CTRL_IE];
      end
      if (wrLen) lenSel  <= regWrData[LEN_W-1:0];
      if (wrDiv) divider <= regWrData[DIV_W-1:0];

      if (strobe.finish) doneFlag <= 1'b1;
      else if (wrCtrl && !regWrData[CTRL_DONE]) doneFlag <= 1'b0;

      if (wrDataReg && !idle) collFlag <= 1'b1;
      else if (wrCtrl && !regWrData[CTRL_COLL]) collFlag <= 1'b0;

      if (strobe.finish && rxFull) ovrFlag <= 1'b1;
      else if (wrCtrl && !regWrData[CTRL_OVR]) ovrFlag <= 1'b0;
    end
  end

  assign xferBusy = !idle;
  assign irq      = irqEn && doneFlag;
endmodule

// File: rtl/spi_port.sv
module spi_port import spi_port_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DIV_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irq,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              nssIn,
  output logic              misoOut
);
  localparam int LEN_W = $clog2(DATA_W);

  dpStrobe_t         strobe;
  logic [LEN_W-1:0]  lenSel;
  logic [DIV_W-1:0]  divider;
  logic              enable, isMaster, irqEn;
  logic              xferBusy, doneFlag, collFlag, ovrFlag;
  logic              rdClear, rxFull, shiftMsb, serIn;
  logic              sckSync, mosiSync, nssSync;
  logic [DATA_W-1:0] rxBuf;
  logic [DATA_W-1:0] ctrlView;

  spi_port_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RESET_VAL(3'b100)) sync_i (
    .clk(clk), .rstN(rstN),
    .din({nssIn, sckIn, mosiIn}),
    .dout({nssSync, sckSync, mosiSync})
  );

  spi_port_ctl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .LEN_W(LEN_W)) ctl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .sckSync(sckSync), .nssSync(nssSync), .rxFull(rxFull),
    .strobe(strobe), .lenSel(lenSel), .divider(divider), .enable(enable),
    .isMaster(isMaster), .irqEn(irqEn), .sckOut(sckOut), .xferBusy(xferBusy),
    .doneFlag(doneFlag), .collFlag(collFlag), .ovrFlag(ovrFlag),
    .rdClear(rdClear), .irq(irq)
  );

  assign serIn = isMaster ? misoIn : mosiSync;

  spi_port_dp #(.DATA_W(DATA_W), .LEN_W(LEN_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData), .lenSel(lenSel),
    .serIn(serIn), .rdClear(rdClear), .shiftMsb(shiftMsb), .rxBuf(rxBuf), .rxFull(rxFull)
  );

  always_comb begin
    ctrlView            = '0;
    ctrlView[CTRL_EN]   = enable;
    ctrlView[CTRL_MST]  = isMaster;
    ctrlView[CTRL_IE]   = irqEn;
    ctrlView[CTRL_DONE] = doneFlag;
    ctrlView[CTRL_COLL] = collFlag;
    ctrlView[CTRL_OVR]  = ovrFlag;
    ctrlView[CTRL_BUSY] = xferBusy;
    case (regAddr)
      ADDR_DATA: regRdData = rxBuf;
      ADDR_CTRL: regRdData = ctrlView;
      ADDR_LEN:  regRdData = DATA_W'(lenSel);
      default:   regRdData = DATA_W'(divider);
    endcase
  end

  assign mosiOut = isMaster && shiftMsb;
  assign misoOut = !isMaster && xferBusy && shiftMsb;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sckOut,
  input logic              mosiOut,
  input logic              irq,
  input logic              xferBusy,
  input logic              doneFlag,
  input logic              collFlag,
  input logic              ovrFlag,
  input logic [DATA_W-1:0] rxBuf
);
  // R2
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    !xferBusy |-> !sckOut);

  // R3
  mosi_steady_at_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sckOut) |-> $stable(mosiOut));

  // R4
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(xferBusy) |-> doneFlag);

  // R5
  irq_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !doneFlag |-> !irq);

  // R6
  coll_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(collFlag) |-> $past(xferBusy));

  // R7
  overrun_keeps_old_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovrFlag) |-> $stable(rxBuf));
endmodule

bind spi_port spi_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .sckOut(sckOut), .mosiOut(mosiOut), .irq(irq),
  .xferBusy(xferBusy), .doneFlag(doneFlag), .collFlag(collFlag),
  .ovrFlag(ovrFlag), .rxBuf(rxBuf)
);

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] regAddr;
  logic       regWr, regRd;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic       irq, sckOut, mosiOut, misoIn, sckIn, mosiIn, nssIn, misoOut;

  int  checks = 0;
  int  bad = 0;
  int  cycle = 0;
  bit  finished = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cycle++;

  spi_port dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq), .sckOut(sckOut),
    .mosiOut(mosiOut), .misoIn(misoIn), .sckIn(sckIn), .mosiIn(mosiIn),
    .nssIn(nssIn), .misoOut(misoOut)
  );

  task automatic expectEq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0; regAddr = 2'd1;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = (a == 2'd0);
    #1 d = regRdData;
    @(negedge clk);
    regRd = 1'b0; regAddr = 2'd1;
  endtask

  // master transfer with the bench acting as the addressed slave
  task automatic mxfer(input logic [7:0] tx, input logic [7:0] slv, input int len,
                       input int div, input int collideAt,
                       output logic [7:0] mosiGot, output int period, output int rises);
    int  k = len - 1;
    bit  prev = 0, pend = 0, fired = 0;
    int  t1 = 0, t2 = 0, guard = 0;
    regWrite(2'd2, 8'(len - 1));
    regWrite(2'd3, 8'(div));
    misoIn = slv[k];
    mosiGot = '0;
    rises = 0;
    regWrite(2'd0, tx);
    while (1) begin
      @(negedge clk);
      guard++;
      if (pend) begin regWr = 1'b0; regAddr = 2'd1; pend = 0; #1; end
      if (sckOut && !prev) begin
        mosiGot = {mosiGot[6:0], mosiOut};
        rises++;
        if (rises == 1) t1 = cycle;
        if (rises == 2) t2 = cycle;
      end
      if (!sckOut && prev) begin
        k--;
        if (k >= 0) misoIn = slv[k];
      end
      prev = sckOut;
      if (!fired && collideAt >= 0 && rises == collideAt) begin
        regAddr = 2'd0; regWrData = 8'hFF; regWr = 1'b1; pend = 1; fired = 1;
      end else if (!pend && regRdData[7] == 1'b0) begin
        break;
      end
      if (guard > 5000) break;
    end
    period = t2 - t1;
  endtask

  // slave transfer with the bench acting as the external master (half period 8 clocks)
  task automatic sxfer(input logic [7:0] preload, input bit doLoad, input logic [7:0] mtx,
                       input int len, output logic [7:0] misoGot);
    regWrite(2'd2, 8'(len - 1));
    if (doLoad) regWrite(2'd0, preload);
    misoGot = '0;
    @(negedge clk); nssIn = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      mosiIn = mtx[i];
      repeat (8) @(negedge clk);
      misoGot = {misoGot[6:0], misoOut};
      sckIn = 1'b1;
      repeat (8) @(negedge clk);
      sckIn = 1'b0;
    end
    repeat (8) @(negedge clk);
    nssIn = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    regRead(2'd1, d); expectEq("R1 ctrl after reset", d, 0);
    regRead(2'd2, d); expectEq("R1 length after reset", d, 0);
    regRead(2'd3, d); expectEq("R1 divider after reset", d, 0);
    regRead(2'd0, d); expectEq("R1 data after reset", d, 0);
    expectEq("R1 pins after reset", {sckOut, mosiOut, misoOut, irq}, 0);
  endtask

  task automatic testMasterBasic();
    logic [7:0] m, d; int p, r;
    regWrite(2'd1, 8'h03);
    mxfer(8'hA5, 8'h3C, 8, 0, -1, m, p, r);
    expectEq("R3 mosi bits 8-bit", m, 8'hA5);
    expectEq("R3 rising edge count", r, 8);
    expectEq("R2 sck period div0", p, 2);
    regRead(2'd1, d); expectEq("R4 done flag set", d[4], 1);
    expectEq("R5 irq low with ie off", irq, 0);
    regRead(2'd0, d); expectEq("R4 received byte", d, 8'h3C);
  endtask

  task automatic testMasterShort();
    logic [7:0] m, d; int p, r;
    regWrite(2'd1, 8'h03);
    mxfer(8'hF6, 8'hEB, 5, 3, -1, m, p, r);
    expectEq("R3 mosi bits 5-bit", m, 8'h16);
    expectEq("R3 rising edges 5-bit", r, 5);
    expectEq("R2 sck period div3", p, 8);
    regRead(2'd0, d); expectEq("R4 received 5-bit right aligned", d, 8'h0B);
  endtask

  task automatic testIrqAndFlags();
    logic [7:0] m, d; int p, r;
    regWrite(2'd1, 8'h07);
    mxfer(8'h01, 8'h01, 1, 1, -1, m, p, r);
    expectEq("R3 single bit out", m, 1);
    expectEq("R5 irq raised", irq, 1);
    regWrite(2'd1, 8'h17);
    regRead(2'd1, d); expectEq("R8 done kept by writing 1", d[4], 1);
    regWrite(2'd1, 8'h07);
    regRead(2'd1, d); expectEq("R8 done cleared by writing 0", d[4], 0);
    expectEq("R5 irq dropped", irq, 0);
    regRead(2'd0, d); expectEq("R4 single bit in", d, 1);
  endtask

  task automatic testOverrun();
    logic [7:0] m, d; int p, r;
    regWrite(2'd1, 8'h03);
    mxfer(8'h11, 8'h5A, 8, 0, -1, m, p, r);
    mxfer(8'h22, 8'hC3, 8, 0, -1, m, p, r);
    regRead(2'd1, d); expectEq("R7 overrun flag", d[6], 1);
    regRead(2'd0, d); expectEq("R7 old byte kept", d, 8'h5A);
    mxfer(8'h33, 8'h77, 8, 0, -1, m, p, r);
    regRead(2'd0, d); expectEq("R8 read frees buffer", d, 8'h77);
    regRead(2'd1, d); expectEq("R8 overrun sticky", d[6], 1);
    regWrite(2'd1, 8'h03);
    regRead(2'd1, d); expectEq("R8 overrun cleared", d[6], 0);
  endtask

  task automatic testCollision();
    logic [7:0] m, d; int p, r;
    regWrite(2'd1, 8'h03);
    mxfer(8'h96, 8'h69, 8, 2, 3, m, p, r);
    expectEq("R6 transfer undisturbed", m, 8'h96);
    expectEq("R6 edge count undisturbed", r, 8);
    regRead(2'd1, d); expectEq("R6 collision flag", d[5], 1);
    regRead(2'd0, d); expectEq("R6 received byte intact", d, 8'h69);
  endtask

  task automatic testDisabled();
    logic [7:0] d; bit sawSck = 0;
    regWrite(2'd1, 8'h00);
    regWrite(2'd0, 8'h55);
    repeat (20) begin @(negedge clk); if (sckOut) sawSck = 1; end
    expectEq("R11 no clock when disabled", sawSck, 0);
    regRead(2'd1, d); expectEq("R11 status idle when disabled", d, 0);
  endtask

  task automatic testSlave();
    logic [7:0] s, d;
    regWrite(2'd1, 8'h01);
    sxfer(8'hC6, 1, 8'h5D, 8, s);
    expectEq("R9 slave miso bits", s, 8'hC6);
    regRead(2'd1, d); expectEq("R9 slave done at nss high", d[4], 1);
    regRead(2'd0, d); expectEq("R9 slave received byte", d, 8'h5D);
    regWrite(2'd1, 8'h01);
    sxfer(8'h00, 0, 8'hA1, 8, s);
    expectEq("R10 resend without reload", s, 8'h5D);
    regRead(2'd0, d); expectEq("R10 second received byte", d, 8'hA1);
    regWrite(2'd1, 8'h01);
    sxfer(8'h3A, 1, 8'h0C, 4, s);
    expectEq("R9 slave 4-bit miso", s, 8'h0A);
    regRead(2'd0, d); expectEq("R9 slave 4-bit received", d, 8'h0C);
  endtask

  initial begin
    rstN = 1'b0; regAddr = 2'd1; regWr = 1'b0; regRd = 1'b0; regWrData = '0;
    misoIn = 1'b0; sckIn = 1'b0; mosiIn = 1'b0; nssIn = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMasterBasic();
    testMasterShort();
    testIrqAndFlags();
    testOverrun();
    testCollision();
    testDisabled();
    testSlave();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule